// File: doc/BRIEF.md
# Seconds Counter with Periodic Alarm

This block keeps time as a 32-bit count of seconds. A fast prescaler counts tick strobes from a 32.768 kHz source, and each time it wraps the seconds counter advances by one. Software can read and write the seconds count through a small word-addressed register port. A read of the seconds count also captures the prescaler at that moment, so the two halves of the time are always consistent with each other.

An alarm compares the next seconds value against a programmed target. In one-shot mode the alarm fires once when the count reaches the target, and it must be rewritten before it can fire again. In periodic mode each match moves the target forward by a programmed interval, with 32-bit wrap-around, so the alarm keeps firing at a fixed period. A match sets a sticky flag. The flag drives a held wake-up request and, when enabled, an interrupt.

The only reset is a power-on reset. No other reset reaches this block, so a system reset leaves the time and the configuration unchanged.

Top module: `rtc_counter_top`

## Requirements
- R1: After power-on reset every register reads 0 and `irq`, `wakeReq` and `rdData` are 0.
- R2: While the run bit (CTRL bit 0) is set, each `tickEn` cycle advances the prescaler. When the prescaler is at DIV-1 it wraps to 0 and the seconds count increments by one.
- R3: While the run bit is clear, `tickEn` is ignored: neither the seconds count nor the prescaler changes.
- R4: A write to SECONDS (address 1) loads the count and clears the prescaler. The write wins over a prescaler wrap in the same cycle.
- R5: A read of SECONDS returns the live count and captures the prescaler. A read of SUBSEC (address 2) returns the captured value, not the live one.
- R6: In one-shot mode (CTRL bit 1 = 0, alarm enable CTRL bit 2 = 1), the flag sets on the tick that moves the count onto ALARM (address 3). The alarm then disarms until ALARM is written again.
- R7: In periodic mode (CTRL bit 1 = 1), each match adds INTERVAL (address 4) to ALARM modulo 2^32 and stays armed.
- R8: The flag (STATUS address 5, bit 0) is sticky. Writing 1 to bit 0 clears it and writing 0 has no effect. A new match in the same cycle as a clear leaves the flag set.
- R9: `wakeReq` equals the flag. `irq` is the flag gated by the interrupt enable (CTRL bit 3). With the alarm enable clear, a match does not set the flag.
- R10: The seconds count wraps from 0xFFFFFFFF to 0.
- R11: `rdData` updates on the clock edge after a cycle with `rdEn` high and holds otherwise. Addresses 6 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| porRstN | input | 1 | Active-low power-on reset, asynchronous |
| tickEn | input | 1 | One-cycle strobe per 32.768 kHz period |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| irq | output | 1 | Alarm interrupt |
| wakeReq | output | 1 | Held wake-up request |

## Verification
Read data appears one edge after `rdEn`. The flag, `irq` and `wakeReq` change on the same edge as the tick that moves the count onto the target. A flag clear takes effect on the edge that takes the STATUS write. The bench drives every input on the falling edge and samples on the following falling edge, so each result is checked in the half-cycle after the edge that produces it. The bench overrides the prescaler divide to 4. This lets the sweeps cover every prescaler phase and every second within a few hundred cycles, with expected counts and alarm periods computed by division and modulo.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [2:0] {
    REG_CTRL  = 3'd0,
    REG_SEC   = 3'd1,
    REG_SUB   = 3'd2,
    REG_ALARM = 3'd3,
    REG_IVAL  = 3'd4,
    REG_STAT  = 3'd5
  } regSel_e;

  typedef struct packed {
    logic countEn;
    logic secLoad;
    logic alarmLoad;
    logic ivalLoad;
    logic snap;
    logic reload;
  } dpStrobe_t;
endpackage

// File: rtl/rtc_datapath.sv
module rtc_datapath #(
  parameter int DIV    = 32768,
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 porRstN,
  input  logic                 tickEn,
  input  rtc_pkg::dpStrobe_t   stb,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    seconds,
  output logic [((DIV > 1) ? $clog2(DIV) : 1)-1:0] subCount,
  output logic [((DIV > 1) ? $clog2(DIV) : 1)-1:0] snapSub,
  output logic [DATA_W-1:0]    target,
  output logic [DATA_W-1:0]    interval,
  output logic                 secHit
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] PMAX = PW'(DIV - 1);

  logic              atMax;
  logic              roll;
  logic [DATA_W-1:0] secNext;

  assign atMax   = (subCount == PMAX);
  assign roll    = stb.countEn & tickEn & atMax & ~stb.secLoad;
  assign secNext = seconds + DATA_W'(1);
  assign secHit  = roll & (secNext == target);

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      seconds  <= '0;
      subCount <= '0;
    end else if (stb.secLoad) begin
      seconds  <= wrData;
      subCount <= '0;
    end else if (stb.countEn && tickEn) begin
      if (atMax) begin
        subCount <= '0;
        seconds  <= secNext;
      end else begin
        subCount <= subCount + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      target <= '0;
    end else if (stb.alarmLoad) begin
      target <= wrData;
    end else if (stb.reload) begin
      target <= target + interval;
    end
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      interval <= '0;
      snapSub  <= '0;
    end else begin
      if (stb.ivalLoad) interval <= wrData;
      if (stb.snap)     snapSub  <= subCount;
    end
  end
endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl #(
  parameter int DIV    = 32768,
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 porRstN,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [2:0]           addr,
  input  logic [3:0]           wrBits,
  input  logic                 secHit,
  input  logic [DATA_W-1:0]    seconds,
  input  logic [((DIV > 1) ? $clog2(DIV) : 1)-1:0] snapSub,
  input  logic [DATA_W-1:0]    target,
  input  logic [DATA_W-1:0]    interval,
  output rtc_pkg::dpStrobe_t   stb,
  output logic [DATA_W-1:0]    rdData,
  output logic                 alarmFire,
  output logic                 flag,
  output logic                 runOn,
  output logic                 relOn,
  output logic                 irq,
  output logic                 wakeReq
);
  import rtc_pkg::*;
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  regSel_e sel;
  logic    almOn, irqOn, armed;
  logic    wrCtrl, wrAlarm, flagClr;

  assign sel     = regSel_e'(addr);
  assign wrCtrl  = wrEn && (sel == REG_CTRL);
  assign wrAlarm = wrEn && (sel == REG_ALARM);
  assign flagClr = wrEn && (sel == REG_STAT) && wrBits[0];

  assign alarmFire = secHit & almOn & armed;

  always_comb begin
    stb           = '0;
    stb.countEn   = runOn;
    stb.secLoad   = wrEn && (sel == REG_SEC);
    stb.alarmLoad = wrAlarm;
    stb.ivalLoad  = wrEn && (sel == REG_IVAL);
    stb.snap      = rdEn && (sel == REG_SEC);
    stb.reload    = alarmFire & relOn;
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      runOn <= 1'b0;
      relOn <= 1'b0;
      almOn <= 1'b0;
      irqOn <= 1'b0;
    end else if (wrCtrl) begin
      runOn <= wrBits[0];
      relOn <= wrBits[1];
      almOn <= wrBits[2];
      irqOn <= wrBits[3];
    end
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      armed <= 1'b0;
      flag  <= 1'b0;
    end else begin
      if (wrAlarm)                 armed <= 1'b1;
      else if (alarmFire && !relOn) armed <= 1'b0;
      if (alarmFire)    flag <= 1'b1;
      else if (flagClr) flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      rdData <= '0;
    end else if (rdEn) begin
      unique case (sel)
        REG_CTRL:  rdData <= {{(DATA_W-4){1'b0}}, irqOn, almOn, relOn, runOn};
        REG_SEC:   rdData <= seconds;
        REG_SUB:   rdData <= {{(DATA_W-PW){1'b0}}, snapSub};
        REG_ALARM: rdData <= target;
        REG_IVAL:  rdData <= interval;
        REG_STAT:  rdData <= {{(DATA_W-1){1'b0}}, flag};
        default:   rdData <= '0;
      endcase
    end
  end

  assign irq     = flag & irqOn;
  assign wakeReq = flag;
endmodule

// File: rtl/rtc_counter_top.sv
module rtc_counter_top #(
  parameter int DIV    = 32768,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic              wakeReq
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  rtc_pkg::dpStrobe_t stb;
  logic [DATA_W-1:0]  seconds, target, interval;
  logic [PW-1:0]      subCount, snapSub;
  logic               secHit, alarmFire, flag, runOn, relOn;

  rtc_datapath #(.DIV(DIV), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .porRstN(porRstN), .tickEn(tickEn), .stb(stb), .wrData(wrData),
    .seconds(seconds), .subCount(subCount), .snapSub(snapSub),
    .target(target), .interval(interval), .secHit(secHit)
  );

  rtc_ctrl #(.DIV(DIV), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .porRstN(porRstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrBits(wrData[3:0]), .secHit(secHit), .seconds(seconds), .snapSub(snapSub),
    .target(target), .interval(interval), .stb(stb), .rdData(rdData),
    .alarmFire(alarmFire), .flag(flag), .runOn(runOn), .relOn(relOn),
    .irq(irq), .wakeReq(wakeReq)
  );
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker #(
  parameter int DIV    = 32768,
  parameter int DATA_W = 32
) (
  input logic               clk,
  input logic               porRstN,
  input logic               wrEn,
  input logic [2:0]         addr,
  input logic [DATA_W-1:0]  wrData,
  input rtc_pkg::dpStrobe_t stb,
  input logic [DATA_W-1:0]  seconds,
  input logic [((DIV > 1) ? $clog2(DIV) : 1)-1:0] subCount,
  input logic [DATA_W-1:0]  target,
  input logic [DATA_W-1:0]  interval,
  input logic               alarmFire,
  input logic               flag,
  input logic               relOn,
  input logic               irq,
  input logic               wakeReq
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  AST_PRESC_RANGE: assert property (@(posedge clk) disable iff (!porRstN)
    subCount <= PW'(DIV - 1)); // R2

  AST_SEC_STEP: assert property (@(posedge clk) disable iff (!porRstN)
    (seconds != $past(seconds)) && !$past(stb.secLoad) |-> seconds == $past(seconds) + DATA_W'(1)); // R2

  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!porRstN)
    !stb.countEn && !stb.secLoad |=> $stable(seconds) && $stable(subCount)); // R3

  AST_FIRE_SETS_FLAG: assert property (@(posedge clk) disable iff (!porRstN)
    alarmFire |=> flag); // R6

  AST_REL_RELOAD: assert property (@(posedge clk) disable iff (!porRstN)
    alarmFire && relOn && !stb.alarmLoad |=> target == $past(target) + $past(interval)); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!porRstN)
    $past(flag) && !$past(wrEn && addr == 3'd5 && wrData[0]) |-> flag); // R8

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!porRstN)
    $past(wrEn && addr == 3'd5 && wrData[0]) && !$past(alarmFire) |-> !flag); // R8

  AST_IRQ_NEEDS_WAKE: assert property (@(posedge clk) disable iff (!porRstN)
    irq |-> wakeReq); // R9

  AST_WAKE_IS_FLAG: assert property (@(posedge clk) disable iff (!porRstN)
    wakeReq == flag); // R9
endmodule

bind rtc_counter_top rtc_checker #(.DIV(DIV), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .porRstN(porRstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .stb(stb), .seconds(seconds), .subCount(subCount), .target(target),
  .interval(interval), .alarmFire(alarmFire), .flag(flag), .relOn(relOn),
  .irq(irq), .wakeReq(wakeReq)
);

// File: tb/tb_rtc_counter_top.sv
module tb_rtc_counter_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;

  logic        clk = 1'b0;
  logic        porRstN = 1'b0;
  logic        tickEn = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq, wakeReq;

  int nChecks = 0, nFails = 0, cycles = 0;
  bit done = 0;

  rtc_counter_top #(.DIV(DIV), .DATA_W(32)) dut (
    .clk(clk), .porRstN(porRstN), .tickEn(tickEn), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irq(irq), .wakeReq(wakeReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rdEn = 1'b1; addr = a;
    @(negedge clk); rdEn = 1'b0; d = rdData;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickEn = 1'b1;
      @(negedge clk); tickEn = 1'b0;
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        nChecks++; nFails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        finishRun();
      end
    end
  end

  initial begin
    logic [31:0] v, held;
    repeat (3) @(negedge clk);
    porRstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v); check("R1 reg reads 0", v, 32'd0);
    end
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 wakeReq", {31'd0, wakeReq}, 32'd0);

    // R3 stopped counter ignores ticks
    tick(6);
    rd(3'd1, v); check("R3 seconds hold", v, 0);
    rd(3'd2, v); check("R3 prescaler hold", v, 0);

    // R2 sweep of every prescaler phase
    wr(3'd0, 32'h1);
    for (int n = 1; n <= 13; n++) begin
      tick(1);
      rd(3'd1, v); check("R2 seconds", v, 32'(n / DIV));
      rd(3'd2, v); check("R2 prescaler", v, 32'(n % DIV));
    end

    // R5 snapshot is not live; R11 rdData holds without rdEn
    rd(3'd1, v);
    rd(3'd2, held);
    tick(2);
    check("R11 rdData holds", rdData, held);
    rd(3'd2, v); check("R5 snapshot stale", v, held);
    rd(3'd1, v);
    rd(3'd2, v); check("R5 snapshot refresh", v, 32'((13 + 2) % DIV));
    rd(3'd6, v); check("R11 addr 6 reads 0", v, 0);
    rd(3'd7, v); check("R11 addr 7 reads 0", v, 0);

    // R4 load clears prescaler, wins over wrap
    wr(3'd1, 32'd40);
    tick(DIV - 1);
    @(negedge clk); wrEn = 1'b1; addr = 3'd1; wrData = 32'd500; tickEn = 1'b1;
    @(negedge clk); wrEn = 1'b0; tickEn = 1'b0;
    rd(3'd1, v); check("R4 load wins", v, 32'd500);
    rd(3'd2, v); check("R4 prescaler cleared", v, 0);

    // R10 wrap
    wr(3'd1, 32'hFFFF_FFFF);
    tick(DIV);
    rd(3'd1, v); check("R10 wrap to 0", v, 0);

    // R6 one-shot alarm, R9 outputs
    wr(3'd1, 32'd10);
    wr(3'd0, 32'hD);
    wr(3'd3, 32'd12);
    tick(2 * DIV - 1);
    check("R6 not yet", {31'd0, wakeReq}, 0);
    tick(1);
    check("R6 fires on target", {31'd0, wakeReq}, 1);
    check("R9 irq with enable", {31'd0, irq}, 1);
    wr(3'd5, 32'd0);
    rd(3'd5, v); check("R8 write 0 keeps flag", v, 1);
    wr(3'd5, 32'd1);
    check("R8 write 1 clears", {31'd0, wakeReq}, 0);
    wr(3'd1, 32'd11);
    tick(DIV);
    check("R6 disarmed after fire", {31'd0, wakeReq}, 0);
    wr(3'd3, 32'd13);
    tick(DIV);
    check("R6 rearmed by write", {31'd0, wakeReq}, 1);
    wr(3'd0, 32'h5);
    check("R9 irq masked", {31'd0, irq}, 0);
    check("R9 wake held", {31'd0, wakeReq}, 1);
    wr(3'd5, 32'd1);
    wr(3'd0, 32'h9);
    wr(3'd3, 32'd14);
    tick(DIV);
    check("R9 alarm disabled no flag", {31'd0, wakeReq}, 0);

    // R8 set wins over clear
    wr(3'd0, 32'hD);
    wr(3'd1, 32'd20);
    wr(3'd3, 32'd21);
    tick(DIV - 1);
    @(negedge clk); wrEn = 1'b1; addr = 3'd5; wrData = 32'd1; tickEn = 1'b1;
    @(negedge clk); wrEn = 1'b0; tickEn = 1'b0;
    check("R8 set beats clear", {31'd0, wakeReq}, 1);
    wr(3'd5, 32'd1);

    // R7 periodic sweep over intervals
    for (int iv = 1; iv <= 3; iv++) begin
      wr(3'd0, 32'hF);
      wr(3'd1, 32'd0);
      wr(3'd4, 32'(iv));
      wr(3'd3, 32'(iv));
      wr(3'd5, 32'd1);
      for (int s = 1; s <= 9; s++) begin
        tick(DIV);
        check("R7 periodic fire", {31'd0, wakeReq}, {31'd0, (s % iv) == 0});
        if (wakeReq) wr(3'd5, 32'd1);
      end
      rd(3'd3, v); check("R7 target advanced", v, 32'((9 / iv) * iv + iv));
    end
    wr(3'd1, 32'hFFFF_FFFE);
    wr(3'd4, 32'd3);
    wr(3'd3, 32'hFFFF_FFFF);
    tick(DIV);
    check("R7 fires at top", {31'd0, wakeReq}, 1);
    rd(3'd3, v); check("R7 reload wraps", v, 32'd2);

    done = 1;
    finishRun();
  end
endmodule